// File: doc/BRIEF.md
# SD Host Command Line Engine

This block runs a single SD host command on the one-bit CMD line. Software, or a register front end above it, presents a 32-bit argument, a 6-bit command index, a 2-bit response-type code and two check enables, then pulses a start strobe. The engine serialises the 48-bit command frame with its CRC7, listens for the card's reply, checks it, and places the payload in four 32-bit response words.

The response-type code sets everything after the command frame. Code 0 (no response) finishes as soon as the end bit has been sent. Code 2 collects a 48-bit reply. Code 1 collects a 136-bit reply. Code 3 collects a 48-bit reply and then holds off completion while the card pulls DAT0 low. Index and CRC checks can each be enabled for a single command. Problems are reported on four separate flags: timeout, CRC, end bit and index.

Each clock cycle carries one CMD-line bit. An inhibit output stays high from the accepted start, through the command, and through a fixed quiet gap after it. A start strobe that arrives while inhibit is high is dropped.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, inhibit, all four flags, done and the CMD-line output enable are low, the CMD line output is high, and all four response words are zero.
- R2: A start strobe seen while inhibit is low sends 48 bits MSB first, one per clock, with the output enable high for exactly those 48 cycles. The bits are: 0, 1, the 6-bit index, the 32-bit argument, the CRC7 (polynomial x^7+x^3+1, register cleared, computed over the first 40 bits), and a final 1. The line is high whenever the enable is low. Index, argument, type and enables are captured at the strobe.
- R3: With response code 0, done rises in the cycle after the end bit is sent, no reply is awaited, and the response words keep their values.
- R4: With response code 2 or 3, the engine receives 48 bits starting at the first low bit on the CMD input. Bits 39:8 of the reply go to response word 0, and words 1 to 3 become zero. The response words change only while inhibit is high.
- R5: With response code 1, the engine receives 136 bits. Reply bits 127:8 are stored as {8'h00, bits 127:8} across response words 3..0, with word 3 in the upper position.
- R6: When CRC checking is enabled, the CRC7 of reply bits 47:8 (48-bit reply) or 127:8 (136-bit reply) is compared with reply bits 7:1, and the CRC error flag is raised on a mismatch. When checking is disabled, the flag stays low.
- R7: When index checking is enabled and the reply is 48 bits, reply bits 45:40 are compared with the command index, and the index error flag is raised on a mismatch. The flag never rises for a 136-bit reply.
- R8: The end-bit error flag is raised whenever the last reply bit (bit 0) is 0.
- R9: If the CMD input stays high for TIMEOUT_CYCLES consecutive cycles after the end bit, the timeout flag is raised and done stays low. A start bit in the last of those cycles is still accepted.
- R10: With response code 3, done waits after the reply until DAT0 is sampled high. Inhibit stays high throughout.
- R11: Inhibit stays high for exactly GAP_CYCLES cycles after completion (done or timeout). The output enable rises only after an accepted strobe, and a strobe during inhibit changes nothing.
- R12: Done and all four flags clear when a strobe is accepted. Done is still raised at the end of a reply that carries check errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CMD-line bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start_i | input | 1 | Start strobe for a new command |
| cmd_arg_i | input | 32 | Command argument |
| cmd_idx_i | input | 6 | Command index |
| resp_type_i | input | 2 | Response code: 0 none, 1 136-bit, 2 48-bit, 3 48-bit with busy |
| crc_chk_en_i | input | 1 | Enable the reply CRC check |
| idx_chk_en_i | input | 1 | Enable the reply index check |
| cmd_line_i | input | 1 | CMD line as received from the card |
| dat0_i | input | 1 | DAT0 level, low while the card is busy |
| cmd_line_o | output | 1 | CMD line value driven to the card |
| cmd_line_oe_o | output | 1 | CMD line driver enable |
| inhibit_o | output | 1 | Command in flight or quiet gap running |
| done_o | output | 1 | Command complete |
| err_timeout_o | output | 1 | No reply start bit in time |
| err_crc_o | output | 1 | Reply CRC mismatch |
| err_end_o | output | 1 | Reply end bit was 0 |
| err_idx_o | output | 1 | Reply index mismatch |
| resp0_o | output | 32 | Response word 0 |
| resp1_o | output | 32 | Response word 1 |
| resp2_o | output | 32 | Response word 2 |
| resp3_o | output | 32 | Response word 3 |

## Verification
The bench keeps the default values, TIMEOUT_CYCLES = 64 and GAP_CYCLES = 8. With these, a reply whose start bit arrives after 63 idle cycles, one that never arrives, and the full quiet gap all fit into short runs, so both sides of the timeout edge are exercised directly. The bench also checks two well-known command frames with fixed CRC bytes. It then runs randomised commands across all four response codes, with single-bit faults injected into the CRC, index and end bit, and with random DAT0 busy lengths.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEND = 3'd1,
        ST_WAIT = 3'd2,
        ST_RECV = 3'd3,
        ST_BUSY = 3'd4,
        ST_GAP  = 3'd5
    } cmd_state_e;

    // response-type codes
    localparam logic [1:0] RT_NONE       = 2'd0;
    localparam logic [1:0] RT_LONG       = 2'd1;
    localparam logic [1:0] RT_SHORT      = 2'd2;
    localparam logic [1:0] RT_SHORT_BUSY = 2'd3;

    localparam int FRAME_BITS = 48;
    localparam int BODY_BITS  = 40;
    localparam int RX_W       = 128;

    localparam logic [6:0] CRC7_POLY = 7'h09;

    function automatic logic [6:0] crc7_next(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? CRC7_POLY : 7'h00);
    endfunction

    // start 0, direction 1, index, argument, CRC7, end 1
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [5:0] idx,
                                                           input logic [31:0] arg);
        logic [BODY_BITS-1:0] body;
        logic [6:0]           c;
        body = {2'b01, idx, arg};
        c    = 7'h00;
        for (int i = BODY_BITS - 1; i >= 0; i--) begin
            c = crc7_next(c, body[i]);
        end
        return {body, c, 1'b1};
    endfunction

endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7
    import sd_cmd_pkg::*;
(
    input  logic [6:0] crc_i,
    input  logic       bit_i,
    input  logic       en_i,
    output logic [6:0] crc_o
);
    always_comb begin
        crc_o = en_i ? crc7_next(crc_i, bit_i) : crc_i;
    end
endmodule

// File: rtl/sd_cmd_rx_check.sv
module sd_cmd_rx_check
    import sd_cmd_pkg::*;
(
    input  logic [RX_W-1:0] frame_i,
    input  logic            long_i,
    input  logic [5:0]      idx_i,
    input  logic [6:0]      crc_i,
    input  logic            crc_en_i,
    input  logic            idx_en_i,
    output logic            err_crc_o,
    output logic            err_idx_o,
    output logic            err_end_o,
    output logic [127:0]    payload_o
);
    always_comb begin
        // R8: end bit
        err_end_o = ~frame_i[0];
        // R6: received CRC field sits in bits 7:1 in both lengths
        err_crc_o = crc_en_i && (crc_i != frame_i[7:1]);
        // R7: index field only exists in the short reply
        err_idx_o = idx_en_i && !long_i && (frame_i[45:40] != idx_i);
        // R4 / R5
        if (long_i) begin
            payload_o = {8'h00, frame_i[127:8]};
        end else begin
            payload_o = {96'h0, frame_i[39:8]};
        end
    end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 64,
    parameter int GAP_CYCLES     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start_i,
    input  logic [31:0] cmd_arg_i,
    input  logic [5:0]  cmd_idx_i,
    input  logic [1:0]  resp_type_i,
    input  logic        crc_chk_en_i,
    input  logic        idx_chk_en_i,
    input  logic        cmd_line_i,
    input  logic        dat0_i,
    output logic        cmd_line_o,
    output logic        cmd_line_oe_o,
    output logic        inhibit_o,
    output logic        done_o,
    output logic        err_timeout_o,
    output logic        err_crc_o,
    output logic        err_end_o,
    output logic        err_idx_o,
    output logic [31:0] resp0_o,
    output logic [31:0] resp1_o,
    output logic [31:0] resp2_o,
    output logic [31:0] resp3_o
);

    localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);
    localparam logic [5:0] TX_LAST    = 6'(FRAME_BITS - 1);
    localparam logic [7:0] RX_LAST_S  = 8'd47;
    localparam logic [7:0] RX_LAST_L  = 8'd135;

    typedef struct packed {
        cmd_state_e            st;
        logic [FRAME_BITS-1:0] tx;
        logic [5:0]            tx_cnt;
        logic [RX_W-2:0]       rx;
        logic [7:0]            rx_cnt;
        logic [TMR_W-1:0]      tmr;
        logic [GAP_W-1:0]      gap;
        logic [5:0]            idx;
        logic [1:0]            rtype;
        logic                  crc_en;
        logic                  idx_en;
        logic [6:0]            crc;
        logic                  done;
        logic                  e_to;
        logic                  e_crc;
        logic                  e_end;
        logic                  e_idx;
        logic [127:0]          resp;
    } regs_t;

    regs_t r_d, r_q;

    logic [RX_W-1:0] rx_shift;
    logic            is_long;
    logic [7:0]      rx_last;
    logic            crc_cover;
    logic            crc_take;
    logic [6:0]      crc_nx;
    logic            chk_crc, chk_idx, chk_end;
    logic [127:0]    chk_payload;

    assign rx_shift  = {r_q.rx, cmd_line_i};
    assign is_long   = (r_q.rtype == RT_LONG);
    assign rx_last   = is_long ? RX_LAST_L : RX_LAST_S;
    // the bit now arriving sits at position rx_last - rx_cnt; CRC spans down to 8
    assign crc_cover = (r_q.rx_cnt <= (rx_last - 8'd8)) && (!is_long || (r_q.rx_cnt >= 8'd8));
    assign crc_take  = crc_cover && ((r_q.st == ST_RECV) ||
                                     ((r_q.st == ST_WAIT) && !cmd_line_i));

    sd_cmd_crc7 u_rx_crc (
        .crc_i (r_q.crc),
        .bit_i (cmd_line_i),
        .en_i  (crc_take),
        .crc_o (crc_nx)
    );

    sd_cmd_rx_check u_rx_chk (
        .frame_i   (rx_shift),
        .long_i    (is_long),
        .idx_i     (r_q.idx),
        .crc_i     (r_q.crc),
        .crc_en_i  (r_q.crc_en),
        .idx_en_i  (r_q.idx_en),
        .err_crc_o (chk_crc),
        .err_idx_o (chk_idx),
        .err_end_o (chk_end),
        .payload_o (chk_payload)
    );

    always_comb begin
        r_d     = r_q;
        r_d.crc = crc_nx;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_start_i) begin                      // R2, R12
                    r_d.st     = ST_SEND;
                    r_d.idx    = cmd_idx_i;
                    r_d.rtype  = resp_type_i;
                    r_d.crc_en = crc_chk_en_i;
                    r_d.idx_en = idx_chk_en_i;
                    r_d.tx     = build_frame(cmd_idx_i, cmd_arg_i);
                    r_d.tx_cnt = '0;
                    r_d.rx     = '0;
                    r_d.rx_cnt = '0;
                    r_d.crc    = '0;
                    r_d.tmr    = '0;
                    r_d.gap    = '0;
                    r_d.done   = 1'b0;
                    r_d.e_to   = 1'b0;
                    r_d.e_crc  = 1'b0;
                    r_d.e_end  = 1'b0;
                    r_d.e_idx  = 1'b0;
                end
            end
            ST_SEND: begin
                r_d.tx     = {r_q.tx[FRAME_BITS-2:0], 1'b1};
                r_d.tx_cnt = r_q.tx_cnt + 6'd1;
                if (r_q.tx_cnt == TX_LAST) begin
                    if (r_q.rtype == RT_NONE) begin         // R3
                        r_d.done = 1'b1;
                        r_d.st   = ST_GAP;
                        r_d.gap  = '0;
                    end else begin
                        r_d.st  = ST_WAIT;
                        r_d.tmr = '0;
                    end
                end
            end
            ST_WAIT: begin
                if (!cmd_line_i) begin
                    r_d.rx     = rx_shift[RX_W-2:0];
                    r_d.rx_cnt = 8'd1;
                    r_d.st     = ST_RECV;
                end else if (r_q.tmr == TMR_LAST) begin     // R9
                    r_d.e_to = 1'b1;
                    r_d.st   = ST_GAP;
                    r_d.gap  = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_RECV: begin
                r_d.rx     = rx_shift[RX_W-2:0];
                r_d.rx_cnt = r_q.rx_cnt + 8'd1;
                if (r_q.rx_cnt == rx_last) begin
                    r_d.e_crc = chk_crc;
                    r_d.e_idx = chk_idx;
                    r_d.e_end = chk_end;
                    r_d.resp  = chk_payload;
                    if (r_q.rtype == RT_SHORT_BUSY) begin   // R10
                        r_d.st = ST_BUSY;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_GAP;
                        r_d.gap  = '0;
                    end
                end
            end
            ST_BUSY: begin
                if (dat0_i) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_GAP;
                    r_d.gap  = '0;
                end
            end
            ST_GAP: begin                                   // R11
                if (r_q.gap == GAP_LAST) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.gap = r_q.gap + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_line_oe_o = (r_q.st == ST_SEND);
    assign cmd_line_o    = cmd_line_oe_o ? r_q.tx[FRAME_BITS-1] : 1'b1;
    assign inhibit_o     = (r_q.st != ST_IDLE);
    assign done_o        = r_q.done;
    assign err_timeout_o = r_q.e_to;
    assign err_crc_o     = r_q.e_crc;
    assign err_end_o     = r_q.e_end;
    assign err_idx_o     = r_q.e_idx;
    assign resp0_o       = r_q.resp[31:0];
    assign resp1_o       = r_q.resp[63:32];
    assign resp2_o       = r_q.resp[95:64];
    assign resp3_o       = r_q.resp[127:96];

endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_start_i,
    input logic        cmd_line_o,
    input logic        cmd_line_oe_o,
    input logic        inhibit_o,
    input logic        done_o,
    input logic        err_timeout_o,
    input logic        err_crc_o,
    input logic        err_end_o,
    input logic        err_idx_o,
    input logic [31:0] resp0_o,
    input logic [31:0] resp1_o,
    input logic [31:0] resp2_o,
    input logic [31:0] resp3_o
);
    logic [5:0] oe_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_run <= '0;
        end else if (cmd_line_oe_o) begin
            oe_run <= oe_run + 6'd1;
        end else begin
            oe_run <= '0;
        end
    end

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_line_oe_o |-> (oe_run < 6'd48)); // R2

    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_line_oe_o |-> cmd_line_o); // R2

    AST_OE_UNDER_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_line_oe_o |-> inhibit_o); // R11

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_line_oe_o) |-> ($past(cmd_start_i) && !$past(inhibit_o))); // R11

    AST_FLAGS_CLEAR_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_line_oe_o |-> !(done_o || err_timeout_o || err_crc_o || err_end_o || err_idx_o)); // R12

    AST_TIMEOUT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout_o |-> !done_o); // R9

    AST_RESP_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_o |=> $stable({resp3_o, resp2_o, resp1_o, resp0_o})); // R4
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_start_i   (cmd_start_i),
    .cmd_line_o    (cmd_line_o),
    .cmd_line_oe_o (cmd_line_oe_o),
    .inhibit_o     (inhibit_o),
    .done_o        (done_o),
    .err_timeout_o (err_timeout_o),
    .err_crc_o     (err_crc_o),
    .err_end_o     (err_end_o),
    .err_idx_o     (err_idx_o),
    .resp0_o       (resp0_o),
    .resp1_o       (resp1_o),
    .resp2_o       (resp2_o),
    .resp3_o       (resp3_o)
);

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;

    localparam int TMO = 64;
    localparam int GAP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start_i = 1'b0;
    logic [31:0] cmd_arg_i = '0;
    logic [5:0]  cmd_idx_i = '0;
    logic [1:0]  resp_type_i = '0;
    logic        crc_chk_en_i = 1'b0;
    logic        idx_chk_en_i = 1'b0;
    logic        cmd_line_i = 1'b1;
    logic        dat0_i = 1'b1;
    logic        cmd_line_o, cmd_line_oe_o, inhibit_o, done_o;
    logic        err_timeout_o, err_crc_o, err_end_o, err_idx_o;
    logic [31:0] resp0_o, resp1_o, resp2_o, resp3_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [127:0] exp_resp = '0;
    logic [47:0]  last_frame;

    always #5 clk = ~clk;

    sd_cmd_engine #(.TIMEOUT_CYCLES(TMO), .GAP_CYCLES(GAP)) i_sd_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i), .cmd_arg_i(cmd_arg_i),
        .cmd_idx_i(cmd_idx_i), .resp_type_i(resp_type_i), .crc_chk_en_i(crc_chk_en_i),
        .idx_chk_en_i(idx_chk_en_i), .cmd_line_i(cmd_line_i), .dat0_i(dat0_i),
        .cmd_line_o(cmd_line_o), .cmd_line_oe_o(cmd_line_oe_o), .inhibit_o(inhibit_o),
        .done_o(done_o), .err_timeout_o(err_timeout_o), .err_crc_o(err_crc_o),
        .err_end_o(err_end_o), .err_idx_o(err_idx_o),
        .resp0_o(resp0_o), .resp1_o(resp1_o), .resp2_o(resp2_o), .resp3_o(resp3_o)
    );

    // CRC7, x^7 + x^3 + 1, over the n low bits of v, MSB first
    function automatic logic [6:0] ref_crc7(input logic [135:0] v, input int n);
        logic [6:0] c = 7'h00;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input logic ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] flags();
        return {done_o, err_timeout_o, err_crc_o, err_end_o, err_idx_o};
    endfunction

    // dly < 0: the card never answers
    task automatic run_cmd(input logic [31:0] arg, input logic [5:0] idx, input logic [1:0] rt,
                           input logic ce, input logic ie, input int dly,
                           input logic fcrc, input logic fidx, input logic fend,
                           input int blen, input logic poke);
        logic [39:0]  body;
        logic [47:0]  want;
        logic [135:0] rsp;
        logic [119:0] pl;
        logic [31:0]  p32;
        logic [6:0]   c;
        logic [5:0]   ridx;
        logic         oe_bad, oe_gap, got_rsp, is_long;
        logic [4:0]   fsave;
        int           rlen, n;
        body    = {2'b01, idx, arg};
        want    = {body, ref_crc7({96'd0, body}, 40), 1'b1};
        is_long = (rt == 2'd1);
        got_rsp = (rt != 2'd0) && (dly >= 0);
        oe_bad  = 1'b0;

        @(negedge clk);
        cmd_arg_i = arg; cmd_idx_i = idx; resp_type_i = rt;
        crc_chk_en_i = ce; idx_chk_en_i = ie; cmd_start_i = 1'b1;
        dat0_i = (rt == 2'd3) ? 1'b0 : 1'b1;
        @(negedge clk);
        cmd_start_i = 1'b0;
        cmd_arg_i = ~arg; cmd_idx_i = ~idx; resp_type_i = ~rt;   // captured values must hold
        chk(flags() == 5'b0, "R12 flags clear on start", {123'd0, flags()}, 128'd0);
        for (int i = 0; i < 48; i++) begin
            last_frame[47 - i] = cmd_line_o;
            if (!cmd_line_oe_o) oe_bad = 1'b1;
            @(negedge clk);
        end
        chk(last_frame == want && !oe_bad, "R2 command frame", {80'd0, last_frame}, {80'd0, want});
        chk(!cmd_line_oe_o && cmd_line_o, "R2 line released high",
            {126'd0, cmd_line_oe_o, cmd_line_o}, 128'd1);

        if (rt != 2'd0) begin
            if (dly < 0) begin
                repeat (TMO - 1) @(negedge clk);
                chk(!err_timeout_o, "R9 no early timeout", {127'd0, err_timeout_o}, 128'd0);
                @(negedge clk);
            end else begin
                p32 = {$urandom};
                pl  = {$urandom, $urandom, $urandom, $urandom};
                ridx = fidx ? (idx ^ 6'h01) : idx;
                if (is_long) begin
                    rlen = 136;
                    c = ref_crc7({16'd0, pl}, 120) ^ {6'd0, fcrc};
                    rsp = {8'h3F, pl, c, ~fend};
                    exp_resp = {8'h00, pl};
                end else begin
                    rlen = 48;
                    c = ref_crc7({96'd0, 2'b00, ridx, p32}, 40) ^ {6'd0, fcrc};
                    rsp = {88'd0, 2'b00, ridx, p32, c, ~fend};
                    exp_resp = {96'd0, p32};
                end
                repeat (dly) @(negedge clk);
                for (int i = 0; i < rlen; i++) begin
                    cmd_line_i = rsp[rlen - 1 - i];
                    @(negedge clk);
                end
                cmd_line_i = 1'b1;
                if (rt == 2'd3) begin
                    chk(!done_o && inhibit_o, "R10 busy holds done",
                        {126'd0, done_o, inhibit_o}, 128'd1);
                    repeat (blen) @(negedge clk);
                    chk(!done_o, "R10 busy still low", {127'd0, done_o}, 128'd0);
                    dat0_i = 1'b1;
                    @(negedge clk);
                end
            end
        end

        chk(done_o == !(rt != 2'd0 && dly < 0),
            (rt == 2'd0) ? "R3 done after frame" : "R12 done on reply",
            {127'd0, done_o}, {127'd0, !(rt != 2'd0 && dly < 0)});
        chk(err_timeout_o == (rt != 2'd0 && dly < 0), "R9 timeout flag",
            {127'd0, err_timeout_o}, {127'd0, (rt != 2'd0 && dly < 0)});
        chk(err_crc_o == (got_rsp && ce && fcrc), "R6 crc flag",
            {127'd0, err_crc_o}, {127'd0, (got_rsp && ce && fcrc)});
        chk(err_idx_o == (got_rsp && ie && fidx && !is_long), "R7 index flag",
            {127'd0, err_idx_o}, {127'd0, (got_rsp && ie && fidx && !is_long)});
        chk(err_end_o == (got_rsp && fend), "R8 end-bit flag",
            {127'd0, err_end_o}, {127'd0, (got_rsp && fend)});
        chk({resp3_o, resp2_o, resp1_o, resp0_o} == exp_resp,
            is_long ? "R5 long response" : "R4 response words",
            {resp3_o, resp2_o, resp1_o, resp0_o}, exp_resp);

        fsave  = flags();
        oe_gap = 1'b0;
        n = 0;
        while (inhibit_o && n < 1000) begin
            cmd_start_i = (n == 0) && poke;
            if (cmd_line_oe_o) oe_gap = 1'b1;
            n++;
            @(negedge clk);
        end
        cmd_start_i = 1'b0;
        dat0_i = 1'b1;
        chk(n == GAP, "R11 quiet gap length", 128'(n), 128'(GAP));
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(!oe_gap && !cmd_line_oe_o && !inhibit_o && flags() == fsave,
                "R11 start during inhibit ignored", {123'd0, flags()}, {123'd0, fsave});
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        repeat (198000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        chk(!inhibit_o && !cmd_line_oe_o && cmd_line_o && flags() == 5'b0,
            "R1 reset outputs", {123'd0, flags()}, 128'd0);
        chk({resp3_o, resp2_o, resp1_o, resp0_o} == 128'd0, "R1 reset response",
            {resp3_o, resp2_o, resp1_o, resp0_o}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // fixed CRC frames
        run_cmd(32'h0, 6'd0, 2'd0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        chk(last_frame == 48'h400000000095, "R2 known frame A", {80'd0, last_frame}, 128'h400000000095);
        run_cmd(32'h1AA, 6'd8, 2'd2, 1'b1, 1'b1, 5, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        chk(last_frame == 48'h48000001AA87, "R2 known frame B", {80'd0, last_frame}, 128'h48000001AA87);

        // directed corners
        run_cmd(32'hDEADBEEF, 6'd2, 2'd1, 1'b1, 1'b0, 3, 1'b0, 1'b0, 1'b0, 0, 1'b0);   // R5
        run_cmd(32'h12345678, 6'd7, 2'd3, 1'b1, 1'b1, 2, 1'b0, 1'b0, 1'b0, 6, 1'b0);   // R10
        run_cmd(32'h0BADF00D, 6'd17, 2'd2, 1'b1, 1'b1, -1, 1'b0, 1'b0, 1'b0, 0, 1'b0); // R9
        run_cmd(32'h0000FFFF, 6'd13, 2'd2, 1'b1, 1'b1, TMO - 1, 1'b0, 1'b0, 1'b0, 0, 1'b0); // R9 edge
        run_cmd(32'hA5A5A5A5, 6'd18, 2'd2, 1'b1, 1'b1, 1, 1'b1, 1'b0, 1'b0, 0, 1'b0);  // R6
        run_cmd(32'hA5A5A5A5, 6'd18, 2'd2, 1'b0, 1'b1, 1, 1'b1, 1'b0, 1'b0, 0, 1'b0);  // R6 off
        run_cmd(32'h5A5A5A5A, 6'd24, 2'd2, 1'b1, 1'b1, 0, 1'b0, 1'b1, 1'b0, 0, 1'b0);  // R7
        run_cmd(32'h5A5A5A5A, 6'd24, 2'd2, 1'b1, 1'b0, 0, 1'b0, 1'b1, 1'b0, 0, 1'b0);  // R7 off
        run_cmd(32'h11111111, 6'd9, 2'd1, 1'b1, 1'b1, 4, 1'b0, 1'b1, 1'b0, 0, 1'b0);   // R7 long
        run_cmd(32'h22222222, 6'd55, 2'd2, 1'b1, 1'b1, 2, 1'b0, 1'b0, 1'b1, 0, 1'b1);  // R8, R11
        run_cmd(32'h33333333, 6'd41, 2'd0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 1'b1);  // R3, R11

        for (int k = 0; k < 30; k++) begin
            logic [1:0] rt;
            logic ce, ie, rsp_ok;
            int dly;
            rt = 2'($urandom % 4);
            if (rt == 2'd1) begin
                ce = 1'b1; ie = 1'b0;
            end else begin
                ce = 1'($urandom % 2); ie = ce & 1'($urandom % 2);
            end
            dly = (rt != 2'd0 && ($urandom % 8) == 0) ? -1 : int'($urandom % TMO);
            rsp_ok = (rt != 2'd0) && (dly >= 0);
            run_cmd($urandom, 6'($urandom), rt, ce, ie, dly,
                    rsp_ok && (($urandom % 5) == 0), rsp_ok && (($urandom % 5) == 0),
                    rsp_ok && (($urandom % 6) == 0), int'($urandom % 5), 1'($urandom % 4 == 0));
        end
        report();
    end

endmodule